// File: doc/BRIEF.md
# Multi-Width Aligned Register File

This block is a 32-entry register file of 32-bit words with two independent read ports and one write port. Each port moves one register, an even/odd pair as a 64-bit value, or an aligned group of four as a 128-bit value. The index on a port names the lowest register of the group. That register supplies the least significant 32 bits, and each higher register supplies the next more significant 32 bits.

Registers 0 and 1 are hardwired to zero. Writes to them are accepted and discarded, so any lane of a read that covers them returns zero. The block checks the alignment of each request. It raises a per-port misalign flag when a pair starts on an odd index, when a quad does not start on a multiple of four, or when the reserved width code is used. A flagged write leaves the file unchanged, and a flagged read returns zero.

The data ports are plain and have no handshake, because a register file serves reads in the same cycle with no back-pressure. Reads are combinational from the stored state. Writes land on the rising clock edge.

Top module: `fprf_wide`

## Requirements
- R1: After reset, every register reads as zero on both read ports, at every width.
- R2: Registers 0 and 1 read as zero on every lane that covers them, whatever has been written to them.
- R3: The width code is 2'b00 for one register, in bits 31:0 with bits 127:32 zero. It is 2'b01 for a pair, in bits 63:0 with bits 127:64 zero. It is 2'b10 for a quad, in bits 127:0.
- R4: On reads and on writes, lane k (bits 32k+31 down to 32k) belongs to register index+k.
- R5: The misalign flag of a port is high, in the same cycle, when the width is 2'b01 with an odd index, when the width is 2'b10 with an index that is not a multiple of 4, or when the width is 2'b11. It is low otherwise.
- R6: A flagged write changes no register. A flagged read returns all 128 bits zero.
- R7: A write with the enable high takes effect at the rising clock edge. A read of the same register in that cycle returns the old value.
- R8: The two read ports are independent. Each returns its own index and width in the same cycle.
- R9: With the write enable low, no register changes, whatever is on the write index, width and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all registers |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Base register of the write |
| wr_width | input | 2 | Write width code |
| wr_data | input | 128 | Write data, lane 0 in bits 31:0 |
| wr_misalign | output | 1 | Write request misaligned or reserved width |
| ra_idx | input | 5 | Base register of read port A |
| ra_width | input | 2 | Read port A width code |
| ra_data | output | 128 | Read port A data |
| ra_misalign | output | 1 | Read port A misaligned or reserved width |
| rb_idx | input | 5 | Base register of read port B |
| rb_width | input | 2 | Read port B width code |
| rb_data | output | 128 | Read port B data |
| rb_misalign | output | 1 | Read port B misaligned or reserved width |

## Verification
A corrupted register, a write that lands on the wrong lane, or a write that should have been suppressed stays hidden until a read covers the damaged register. It then shows as a wrong 32-bit lane on that read, in the same cycle as the read. The reads are combinational, so the earliest exposure is the cycle after the faulty write edge. The bench therefore mixes random wide and narrow reads with the writes on both ports, so that any register is read back within a few cycles. Wrong misalign decoding shows at once on the flag and on the zeroed read data.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic [1:0] {
    W_SINGLE = 2'b00,
    W_PAIR   = 2'b01,
    W_QUAD   = 2'b10,
    W_RSVD   = 2'b11
  } width_e;

  localparam int unsigned MAX_LANES = 4;
endpackage

// File: rtl/fprf_align.sv
module fprf_align
  import fprf_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic [1:0]           width,
  output logic                 misalign,
  output logic [MAX_LANES-1:0] lane_mask
);
  logic [MAX_LANES-1:0] raw_mask;
  logic                 bad;

  always_comb begin
    unique case (width_e'(width))
      W_SINGLE: begin raw_mask = 4'b0001; bad = 1'b0;       end
      W_PAIR:   begin raw_mask = 4'b0011; bad = idx[0];     end
      W_QUAD:   begin raw_mask = 4'b1111; bad = |idx[1:0];  end
      default:  begin raw_mask = 4'b0000; bad = 1'b1;       end
    endcase
  end

  assign misalign  = bad;
  assign lane_mask = bad ? '0 : raw_mask;
endmodule

// File: rtl/fprf_store.sv
module fprf_store
  import fprf_pkg::*;
#(
  parameter int unsigned NREGS     = 32,
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned ZERO_REGS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [MAX_LANES-1:0]               wr_mask,
  input  logic [$clog2(NREGS)-1:0]           wr_base,
  input  logic [MAX_LANES*LANE_W-1:0]        wr_data,
  output logic [NREGS-1:0][LANE_W-1:0]       regs_q
);
  localparam int unsigned IDX_W = $clog2(NREGS);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    if (r < ZERO_REGS) begin : g_zero
      assign regs_q[r] = '0;
    end else begin : g_live
      logic              hit;
      logic [LANE_W-1:0] nxt;

      always_comb begin
        hit = 1'b0;
        nxt = regs_q[r];
        for (int k = 0; k < MAX_LANES; k++) begin
          if (wr_mask[k] && (wr_base + IDX_W'(k)) == IDX_W'(r)) begin
            hit = 1'b1;
            nxt = wr_data[k*LANE_W +: LANE_W];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n)             regs_q[r] <= '0;
        else if (wr_en && hit)  regs_q[r] <= nxt;
      end
    end
  end

  // R2: hardwired entries never hold anything but zero
  a_r2_hardwired: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[0] == '0 && regs_q[1] == '0));
endmodule

// File: rtl/fprf_rdport.sv
module fprf_rdport
  import fprf_pkg::*;
#(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned LANE_W = 32
) (
  input  logic [NREGS-1:0][LANE_W-1:0] regs_q,
  input  logic [$clog2(NREGS)-1:0]     idx,
  input  logic [MAX_LANES-1:0]         lane_mask,
  output logic [MAX_LANES*LANE_W-1:0]  data
);
  localparam int unsigned IDX_W = $clog2(NREGS);

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel = idx + IDX_W'(k);
    assign data[k*LANE_W +: LANE_W] = lane_mask[k] ? regs_q[sel] : '0;
  end
endmodule

// File: rtl/fprf_wide.sv
module fprf_wide
  import fprf_pkg::*;
#(
  parameter int unsigned NREGS     = 32,
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned ZERO_REGS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NREGS)-1:0]      wr_idx,
  input  logic [1:0]                    wr_width,
  input  logic [MAX_LANES*LANE_W-1:0]   wr_data,
  output logic                          wr_misalign,
  input  logic [$clog2(NREGS)-1:0]      ra_idx,
  input  logic [1:0]                    ra_width,
  output logic [MAX_LANES*LANE_W-1:0]   ra_data,
  output logic                          ra_misalign,
  input  logic [$clog2(NREGS)-1:0]      rb_idx,
  input  logic [1:0]                    rb_width,
  output logic [MAX_LANES*LANE_W-1:0]   rb_data,
  output logic                          rb_misalign
);
  localparam int unsigned IDX_W  = $clog2(NREGS);
  localparam int unsigned PORT_W = MAX_LANES * LANE_W;

  logic [NREGS-1:0][LANE_W-1:0] regs_q;
  logic [MAX_LANES-1:0]         wr_mask, ra_mask, rb_mask;

  fprf_align #(.IDX_W(IDX_W)) u_wr_align (
    .idx(wr_idx), .width(wr_width), .misalign(wr_misalign), .lane_mask(wr_mask)
  );
  fprf_align #(.IDX_W(IDX_W)) u_ra_align (
    .idx(ra_idx), .width(ra_width), .misalign(ra_misalign), .lane_mask(ra_mask)
  );
  fprf_align #(.IDX_W(IDX_W)) u_rb_align (
    .idx(rb_idx), .width(rb_width), .misalign(rb_misalign), .lane_mask(rb_mask)
  );

  fprf_store #(.NREGS(NREGS), .LANE_W(LANE_W), .ZERO_REGS(ZERO_REGS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_base(wr_idx), .wr_data(wr_data), .regs_q(regs_q)
  );

  fprf_rdport #(.NREGS(NREGS), .LANE_W(LANE_W)) u_rd_a (
    .regs_q(regs_q), .idx(ra_idx), .lane_mask(ra_mask), .data(ra_data)
  );
  fprf_rdport #(.NREGS(NREGS), .LANE_W(LANE_W)) u_rd_b (
    .regs_q(regs_q), .idx(rb_idx), .lane_mask(rb_mask), .data(rb_data)
  );

  a_r5_pair_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_width == 2'b01 && ra_idx[0]) |-> ra_misalign);

  a_r5_quad_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_width == 2'b10 && ra_idx[1:0] != 2'b00) |-> ra_misalign);

  a_r6_misread_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rb_misalign |-> rb_data == '0);

  a_r6_miswrite_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_misalign) |=> $stable(regs_q));

  a_r9_idle_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

  a_r3_single_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_width == 2'b00) |-> ra_data[PORT_W-1:LANE_W] == '0);

  a_r2_base_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == '0 && !ra_misalign) |-> ra_data[2*LANE_W-1:0] == '0);

  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_misalign && wr_width == 2'b00 && wr_idx >= IDX_W'(ZERO_REGS))
    |=> (!(ra_width == 2'b00 && ra_idx == $past(wr_idx))
         || ra_data[LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));
endmodule

// File: tb/sim_fprf_wide.sv
`timescale 1ns/1ps
module sim_fprf_wide;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_idx, ra_idx, rb_idx;
  logic [1:0]   wr_width, ra_width, rb_width;
  logic [127:0] wr_data, ra_data, rb_data;
  logic         wr_misalign, ra_misalign, rb_misalign;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [31:0] m [32];

  always #2.5 clk = ~clk;

  fprf_wide u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width), .wr_data(wr_data),
    .wr_misalign(wr_misalign),
    .ra_idx(ra_idx), .ra_width(ra_width), .ra_data(ra_data), .ra_misalign(ra_misalign),
    .rb_idx(rb_idx), .rb_width(rb_width), .rb_data(rb_data), .rb_misalign(rb_misalign)
  );

  function automatic bit exp_mis(logic [4:0] idx, logic [1:0] w);
    case (w)
      2'b00:   return 1'b0;
      2'b01:   return idx[0];
      2'b10:   return idx[1:0] != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int n_lanes(logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [127:0] exp_rd(logic [4:0] idx, logic [1:0] w);
    logic [127:0] v = '0;
    if (exp_mis(idx, w)) return v;
    for (int k = 0; k < n_lanes(w); k++) begin
      int r = int'(idx) + k;
      v[k*32 +: 32] = (r < 2) ? 32'h0 : m[r];
    end
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string auto_tag(logic [4:0] idx, logic [1:0] w);
    if (exp_mis(idx, w)) return "R6";
    if (w == 2'b00)      return "R3";
    return "R4";
  endfunction

  task automatic cyc(string tag, logic we, logic [4:0] wi, logic [1:0] ww,
                     logic [127:0] wd, logic [4:0] ai, logic [1:0] aw,
                     logic [4:0] bi, logic [1:0] bw);
    string ta, tb;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_width = ww; wr_data = wd;
    ra_idx = ai; ra_width = aw; rb_idx = bi; rb_width = bw;
    #1;
    ta = (tag == "") ? auto_tag(ai, aw) : tag;
    tb = (tag == "") ? auto_tag(bi, bw) : tag;
    chk({ta, " port A data"}, ra_data, exp_rd(ai, aw));
    chk({tb, " port B data"}, rb_data, exp_rd(bi, bw));
    chk("R5 port A flag", 128'(ra_misalign), 128'(exp_mis(ai, aw)));
    chk("R5 port B flag", 128'(rb_misalign), 128'(exp_mis(bi, bw)));
    chk("R5 write flag",  128'(wr_misalign), 128'(exp_mis(wi, ww)));
    @(posedge clk);
    if (we && !exp_mis(wi, ww))
      for (int k = 0; k < n_lanes(ww); k++) m[int'(wi) + k] = wd[k*32 +: 32];
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [1:0] rnd_w();
    int p = $urandom_range(0, 15);
    return (p < 5) ? 2'b00 : (p < 10) ? 2'b01 : (p < 15) ? 2'b10 : 2'b11;
  endfunction

  function automatic logic [4:0] rnd_idx(logic [1:0] w);
    logic [4:0] i = 5'($urandom_range(0, 31));
    if ($urandom_range(0, 3) != 0) begin
      if (w == 2'b01) i[0] = 1'b0;
      if (w == 2'b10) i[1:0] = 2'b00;
    end
    return i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 32; r++) m[r] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_width = '0; wr_data = '0;
    ra_idx = '0; ra_width = '0; rb_idx = '0; rb_width = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: everything zero after reset
    for (int g = 0; g < 8; g++)
      cyc("R1", 1'b0, 5'd0, 2'b00, '0, 5'(g*4), 2'b10, 5'(31 - g), 2'b00);

    // R2: quad write at base 0 keeps lanes 0 and 1 zero
    cyc("R2", 1'b1, 5'd0, 2'b10, 128'h44444444_33333333_22222222_11111111,
        5'd0, 2'b10, 5'd1, 2'b00);
    cyc("R2", 1'b0, 5'd0, 2'b00, '0, 5'd0, 2'b10, 5'd0, 2'b01);
    cyc("R2", 1'b1, 5'd1, 2'b00, 128'hDEADBEEF, 5'd1, 2'b00, 5'd2, 2'b10);
    cyc("R2", 1'b0, 5'd0, 2'b00, '0, 5'd1, 2'b00, 5'd0, 2'b10);

    // R4: lane order on a quad at base 12, read back as pairs and singles
    cyc("R4", 1'b1, 5'd12, 2'b10, 128'hDDDD000D_CCCC000C_BBBB000B_AAAA000A,
        5'd12, 2'b10, 5'd14, 2'b01);
    cyc("R4", 1'b0, 5'd0, 2'b00, '0, 5'd14, 2'b01, 5'd13, 2'b00);
    cyc("R3", 1'b0, 5'd0, 2'b00, '0, 5'd12, 2'b00, 5'd12, 2'b01);

    // R7: same-cycle read returns old value, new value next cycle
    cyc("R7", 1'b1, 5'd13, 2'b00, 128'h12345678, 5'd13, 2'b00, 5'd12, 2'b10);
    cyc("R7", 1'b0, 5'd0, 2'b00, '0, 5'd13, 2'b00, 5'd12, 2'b10);

    // R6: misaligned pair, misaligned quad and reserved width writes are dropped
    cyc("R6", 1'b1, 5'd13, 2'b01, {4{32'hBAD0BAD0}}, 5'd13, 2'b01, 5'd12, 2'b10);
    cyc("R6", 1'b1, 5'd14, 2'b10, {4{32'hBAD1BAD1}}, 5'd12, 2'b10, 5'd16, 2'b10);
    cyc("R6", 1'b1, 5'd12, 2'b11, {4{32'hBAD2BAD2}}, 5'd12, 2'b11, 5'd12, 2'b10);

    // R9: write enable low leaves the file unchanged
    cyc("R9", 1'b0, 5'd12, 2'b10, {4{32'hFEEDFACE}}, 5'd12, 2'b10, 5'd13, 2'b00);
    cyc("R9", 1'b0, 5'd0, 2'b00, '0, 5'd12, 2'b10, 5'd14, 2'b01);

    // R8: both ports read different groups in one cycle
    cyc("R8", 1'b1, 5'd28, 2'b10, rnd128(), 5'd12, 2'b10, 5'd30, 2'b01);
    cyc("R8", 1'b0, 5'd0, 2'b00, '0, 5'd28, 2'b10, 5'd12, 2'b00);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] ww = rnd_w();
      logic [1:0] aw = rnd_w();
      logic [1:0] bw = rnd_w();
      cyc("", ($urandom_range(0, 2) != 0), rnd_idx(ww), ww, rnd128(),
          rnd_idx(aw), aw, rnd_idx(bw), bw);
    end

    // final sweep of whole file
    for (int g = 0; g < 8; g++)
      cyc("R4", 1'b0, 5'd0, 2'b00, '0, 5'(g*4), 2'b10, 5'(g*4 + 2), 2'b01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule